// File: doc/BRIEF.md
# Port Interrupt Status Controller

This block gathers up to 32 interrupt sources of one link port into a single interrupt line for the host. The four lowest sources are legacy wire interrupts. They are level-sensitive, and the status register shows them as they are on the wire. Every other source is edge-sensitive. A rising edge on one of them latches a sticky status bit, and that bit stays set until software writes a 1 to it.

A mask register decides which status bits can raise the combined output. Software never rewrites the mask as a whole. It writes ones to a set alias to mask sources and writes ones to a clear alias to unmask them, so no read-modify-write sequence is needed. The combined output is a registered OR of every status bit that is not masked.

Top module: `port_irq_agg`

## Requirements
- R1: After reset every edge status bit (bits 4 to 31) is 0, every mask bit is 1 and `irq_o` is 0.
- R2: Reading address 0x100 (status) returns the live levels of `src_i[3:0]` in bits 3 to 0, with no latching.
- R3: A write of ones to address 0x100 has no effect on status bits 0 to 3, which keep following the wires.
- R4: A rising edge on `src_i[k]` for k in 4 to 31 sets status bit k. The bit stays set after the source falls.
- R5: Writing to address 0x100 clears each edge status bit written as 1 and leaves each bit written as 0 unchanged.
- R6: Writing to address 0x108 (mask set) sets every mask bit written as 1 and leaves the other mask bits unchanged.
- R7: Writing to address 0x10C (mask clear) clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R8: Reads of 0x104, 0x108 and 0x10C all return the current mask. Writes to 0x104 are ignored. Reads of any other address return 0.
- R9: `irq_o` equals the OR over all 32 bits of (status AND NOT mask) as it was one clock earlier.
- R10: If a rising edge on an edge source arrives in the same cycle as a write-1-to-clear of that bit, the bit ends up set.
- R11: Writing all ones to 0x108 and then all ones to 0x100 leaves every mask bit at 1, every edge status bit at 0, and `irq_o` low.
- R12: An edge source that stays high does not set its status bit again after the bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| src_i | input | 32 | Source vector; bits 3:0 are level wires, the rest are edge events |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
A wrong status or mask bit reaches the outside world in two ways. It shows up on `bus_rdata` as soon as the register is addressed. It also shows up on `irq_o` one clock later, provided the matching bit in the other register allows it through. The bench therefore reads both registers back after every stimulus. It also samples `irq_o` exactly one edge after each mask or status change, so that both a lost event and a stale output appear within two cycles. The collision case and the held-high source are driven on exact edges, because an error in edge detection or in the order of set and clear only becomes visible there.

// File: rtl/port_irq_agg.sv
module port_irq_agg #(
  parameter int NSRC     = 32,
  parameter int NLVL     = 4,
  parameter int AW       = 12,
  parameter logic [AW-1:0] STAT_A = 12'h100,
  parameter logic [AW-1:0] MASK_A = 12'h104,
  parameter logic [AW-1:0] MSET_A = 12'h108,
  parameter logic [AW-1:0] MCLR_A = 12'h10C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_o
);
  localparam logic [NSRC-1:0] LVL_BITS  = NSRC'((64'd1 << NLVL) - 64'd1);
  localparam logic [NSRC-1:0] EDGE_BITS = ~LVL_BITS;

  logic [NSRC-1:0] src_q, edge_q, mask_q, stat_view, rise, w1c;

  assign rise      = src_i & ~src_q & EDGE_BITS;
  assign w1c       = (bus_we && bus_addr == STAT_A) ? bus_wdata : '0;
  assign stat_view = (edge_q & EDGE_BITS) | (src_i & LVL_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      edge_q <= '0;
      mask_q <= '1;
      irq_o  <= 1'b0;
    end else begin
      src_q  <= src_i;
      edge_q <= ((edge_q & ~w1c) | rise) & EDGE_BITS;
      if (bus_we && bus_addr == MSET_A) mask_q <= mask_q | bus_wdata;
      else if (bus_we && bus_addr == MCLR_A) mask_q <= mask_q & ~bus_wdata;
      irq_o  <= |(stat_view & ~mask_q);
    end
  end

  always_comb begin
    unique case (bus_addr)
      STAT_A:                 bus_rdata = stat_view;
      MASK_A, MSET_A, MCLR_A: bus_rdata = mask_q;
      default:                bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/port_irq_agg_chk.sv
module port_irq_agg_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic            irq_o,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] edge_q,
  input logic [NSRC-1:0] src_q
);
  AST_INTX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 12'h100 |-> bus_rdata[3:0] == src_i[3:0]); // R2
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h108) |=> (mask_q & $past(bus_wdata)) == $past(bus_wdata)); // R6
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h10C) |=> (mask_q & $past(bus_wdata)) == '0); // R7
  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h104) |=> $stable(mask_q)); // R8
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(((edge_q & ~32'hF) | (src_i & 32'hF)) & ~mask_q))); // R9
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(src_i & ~src_q) & ~32'hF) & ~edge_q) == '0); // R10
endmodule

bind port_irq_agg port_irq_agg_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .mask_q(mask_q), .edge_q(edge_q), .src_q(src_q));

// File: tb/sim_port_irq_agg.sv
module sim_port_irq_agg;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq_o;
  logic [31:0] src_i = '0, bus_wdata = '0, bus_rdata;
  logic [11:0] bus_addr = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  port_irq_agg u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int b);
    @(negedge clk); src_i[b] = 1'b1;
    @(negedge clk); src_i[b] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h100, v); chk("R1 status", v, 32'h0);
    rd(12'h104, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); src_i[3:0] = 4'b0101;
    rd(12'h100, v); chk("R2 live high", v, 32'h5);
    wr(12'h100, 32'hF);
    rd(12'h100, v); chk("R3 w1c no effect", v, 32'h5);
    @(negedge clk); src_i[3:0] = 4'b0000;
    rd(12'h100, v); chk("R2 live low", v, 32'h0);
    wr(12'h10C, 32'h2);
    @(negedge clk); src_i[1] = 1'b1;
    @(negedge clk); chk("R9 level irq", {31'b0, irq_o}, 32'h1);
    src_i[1] = 1'b0;
    @(negedge clk); chk("R9 level irq drop", {31'b0, irq_o}, 32'h0);
    wr(12'h108, 32'h2);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    pulse(12);
    rd(12'h100, v); chk("R4 latch", v, 32'h1000);
    @(negedge clk); chk("R9 masked", {31'b0, irq_o}, 32'h0);
    wr(12'h10C, 32'h1000);
    @(negedge clk); chk("R9 unmasked", {31'b0, irq_o}, 32'h1);
    wr(12'h100, 32'h4000);
    rd(12'h100, v); chk("R5 zero bits kept", v, 32'h1000);
    wr(12'h100, 32'h1000);
    rd(12'h100, v); chk("R5 cleared", v, 32'h0);
    @(negedge clk); chk("R9 cleared irq", {31'b0, irq_o}, 32'h0);
    wr(12'h108, 32'h1000);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(12'h10C, 32'h00F0_0F00);
    rd(12'h104, v); chk("R7 clear", v, 32'hFF0F_F0FF);
    wr(12'h108, 32'h0030_0000);
    rd(12'h108, v); chk("R6 set", v, 32'hFF3F_F0FF);
    wr(12'h104, 32'h0);
    rd(12'h10C, v); chk("R8 direct write ignored", v, 32'hFF3F_F0FF);
    rd(12'h200, v); chk("R8 unmapped", v, 32'h0);
    wr(12'h108, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(23);
    @(negedge clk);
    src_i[23] = 1'b1; bus_addr = 12'h100; bus_wdata = 32'h0080_0000; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; src_i[23] = 1'b0;
    rd(12'h100, v); chk("R10 event wins", v, 32'h0080_0000);
    wr(12'h100, 32'h0080_0000);
  endtask

  task automatic t_held();
    logic [31:0] v;
    @(negedge clk); src_i[31] = 1'b1;
    @(negedge clk);
    wr(12'h100, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rd(12'h100, v); chk("R12 no relatch", v, 32'h0);
    src_i[31] = 1'b0;
  endtask

  task automatic t_all();
    logic [31:0] v;
    wr(12'h10C, 32'hFFFF_FFFF);
    pulse(17); pulse(4); pulse(19);
    @(negedge clk); chk("R9 any bit", {31'b0, irq_o}, 32'h1);
    wr(12'h108, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); chk("R11 edges clear", v, 32'h0);
    rd(12'h104, v); chk("R11 all masked", v, 32'hFFFF_FFFF);
    @(negedge clk); chk("R11 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_level(); t_edge(); t_mask(); t_collide(); t_held(); t_all();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule